// File: doc/BRIEF.md
# Integer Register File with Delayed Branch Operands

This block holds the sixteen integer registers of a vector coprocessor's lower pipeline. One decoded lower instruction arrives per clock, qualified by a valid bit. Each instruction carries two source indices, a destination index, a write enable with write data, and three marker bits: conditional branch, flag-read instruction and pipeline stall. The block always returns the current value of both sources on the ordinary read ports. The register is written at the end of the cycle in which the instruction is presented.

A second pair of outputs feeds the comparator of a conditional branch. These outputs do not always show the current value. If the register was written by the instruction just before the branch, the branch sees the value the register held before that write. This also applies when the register was updated by a short run of read-modify-write instructions: the branch then sees the value from before the first instruction of the run. A single tracker holds the run's register index, its length and the saved pre-run value. Flag-read writes are always visible to the branch at once. A stall cuts a run short.

Top module: `ireg_branch_file`

## Requirements
- R1: Index bit 4 of every source and destination field is ignored, so index 18 (5'b10010) addresses register 2 on all ports.
- R2: Register 0 reads as zero on every output, and writes to it change nothing and start no run.
- R3: `rd_a`/`rd_b` always show the register's current value, including a write made by the instruction in the previous clock.
- R4: A plain write (valid, write enabled, not flag-read, not branch, nonzero destination) starts a run of length 1. In the following instruction, a branch operand naming that register returns the value it held before the write.
- R5: A write marked flag-read starts no run and ends any open run. A branch that follows it sees the newly written value.
- R6: An instruction extends the run when it writes the run's register, reads that register on either source, is not stalled, and the run is shorter than 4. Up to 4 instructions share one saved pre-run value.
- R7: A fifth read-modify-write of the same register starts a new run. The branch then sees the value left by the fourth instruction.
- R8: A stalled write does not extend a run. It starts a new run whose saved value is the register content just before the stalled instruction.
- R9: A valid instruction ends the run, so that later branches see current values, if it does not write or if it is a branch. A plain write to another register, or to the same register without reading it, starts a new run on its own destination instead.
- R10: Cycles with `in_valid` low neither extend, restart nor end a run, and write nothing.
- R11: Only the branch operand whose index matches the run's register is substituted. The other operand shows the current value.
- R12: After reset, all registers are zero and no run is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| in_src_a | input | 5 | First source index field |
| in_src_b | input | 5 | Second source index field |
| in_dst | input | 5 | Destination index field |
| in_wr_en | input | 1 | Instruction writes the destination |
| in_wr_data | input | 16 | Value to write |
| in_is_branch | input | 1 | Instruction is a conditional branch (never writes) |
| in_is_flagrd | input | 1 | Instruction is a flag-read instruction |
| in_stall | input | 1 | Instruction issued after a pipeline stall |
| rd_a | output | 16 | Current value of source A |
| rd_b | output | 16 | Current value of source B |
| br_a | output | 16 | Branch comparison operand A |
| br_b | output | 16 | Branch comparison operand B |

## Verification
The hardest state to reach from the ports is a run at its limit of 4. The next instruction then decides whether the run extends or restarts. This depends on the run length together with the stall bit, the match of either source, and idle cycles placed inside the run. Directed sequences build runs of length 4 and 5 on one register. They also place a stalled write and idle gaps inside a run. A long random phase follows on a pool of three registers, with aliased indices, so that runs, restarts and breaks occur in many orders. A behavioural model compares all four outputs on every instruction.

// File: rtl/ireg_pkg.sv
package ireg_pkg;
    localparam int WORD_W    = 16;
    localparam int NREG      = 16;
    localparam int FIELD_W   = 5;
    localparam int AW        = $clog2(NREG);
    localparam int MAX_RUN   = 4;
    localparam int RUNLEN_W  = $clog2(MAX_RUN + 1);

    typedef logic [WORD_W-1:0]   word_t;
    typedef logic [AW-1:0]       ridx_t;
    typedef logic [RUNLEN_W-1:0] runlen_t;

    typedef struct packed {
        logic    act;
        ridx_t   idx;
        word_t   saved;
        runlen_t len;
    } run_t;

    function automatic ridx_t fold_idx(input logic [FIELD_W-1:0] f);
        return f[AW-1:0];
    endfunction
endpackage

// File: rtl/ireg_bank.sv
module ireg_bank
    import ireg_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  we,
    input  ridx_t waddr,
    input  word_t wdata,
    input  ridx_t ra,
    input  ridx_t rb,
    input  ridx_t rc,
    output word_t qa,
    output word_t qb,
    output word_t qc
);
    word_t mem_q [NREG];
    word_t mem_d [NREG];

    always_comb begin
        for (int i = 0; i < NREG; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (we && (waddr != '0)) begin
            mem_d[waddr] = wdata;
        end
        mem_d[0] = '0;
    end

    for (genvar g = 0; g < NREG; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem_q[g] <= '0;
            end else begin
                mem_q[g] <= mem_d[g];
            end
        end
    end

    assign qa = mem_q[ra];
    assign qb = mem_q[rb];
    assign qc = mem_q[rc];
endmodule

// File: rtl/ireg_run_track.sv
module ireg_run_track
    import ireg_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  valid,
    input  logic  plain_wr,
    input  logic  stall,
    input  ridx_t dst,
    input  ridx_t src_a,
    input  ridx_t src_b,
    input  word_t dst_now,
    output run_t  run
);
    run_t run_d;
    run_t run_q;
    logic reads_dst;
    logic may_extend;

    always_comb begin
        reads_dst  = (src_a == dst) || (src_b == dst);
        may_extend = run_q.act && (run_q.idx == dst) && reads_dst
                     && !stall && (run_q.len < runlen_t'(MAX_RUN));
        run_d = run_q;
        if (valid) begin
            if (plain_wr) begin
                if (may_extend) begin
                    run_d.len = run_q.len + runlen_t'(1);
                end else begin
                    run_d.act   = 1'b1;
                    run_d.idx   = dst;
                    run_d.saved = dst_now;
                    run_d.len   = runlen_t'(1);
                end
            end else begin
                run_d = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else begin
            run_q <= run_d;
        end
    end

    assign run = run_q;
endmodule

// File: rtl/ireg_branch_file.sv
module ireg_branch_file
    import ireg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [FIELD_W-1:0] in_src_a,
    input  logic [FIELD_W-1:0] in_src_b,
    input  logic [FIELD_W-1:0] in_dst,
    input  logic               in_wr_en,
    input  logic [WORD_W-1:0]  in_wr_data,
    input  logic               in_is_branch,
    input  logic               in_is_flagrd,
    input  logic               in_stall,
    output logic [WORD_W-1:0]  rd_a,
    output logic [WORD_W-1:0]  rd_b,
    output logic [WORD_W-1:0]  br_a,
    output logic [WORD_W-1:0]  br_b
);
    ridx_t a_i;
    ridx_t b_i;
    ridx_t d_i;
    logic  wr_any;
    logic  wr_plain;
    word_t dst_now;
    run_t  run;

    assign a_i      = fold_idx(in_src_a);
    assign b_i      = fold_idx(in_src_b);
    assign d_i      = fold_idx(in_dst);
    assign wr_any   = in_valid && in_wr_en && !in_is_branch && (d_i != '0);
    assign wr_plain = wr_any && !in_is_flagrd;

    ireg_bank u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_any),
        .waddr (d_i),
        .wdata (in_wr_data),
        .ra    (a_i),
        .rb    (b_i),
        .rc    (d_i),
        .qa    (rd_a),
        .qb    (rd_b),
        .qc    (dst_now)
    );

    ireg_run_track u_run (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid    (in_valid),
        .plain_wr (wr_plain),
        .stall    (in_stall),
        .dst      (d_i),
        .src_a    (a_i),
        .src_b    (b_i),
        .dst_now  (dst_now),
        .run      (run)
    );

    always_comb begin
        br_a = (run.act && (run.idx == a_i)) ? run.saved : rd_a;
        br_b = (run.act && (run.idx == b_i)) ? run.saved : rd_b;
    end
endmodule

// File: rtl/ireg_branch_file_chk.sv
module ireg_branch_file_chk
    import ireg_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic [FIELD_W-1:0] in_src_a,
    input logic [FIELD_W-1:0] in_src_b,
    input logic [FIELD_W-1:0] in_dst,
    input logic               in_wr_en,
    input logic [WORD_W-1:0]  in_wr_data,
    input logic               in_is_branch,
    input logic               in_is_flagrd,
    input logic [WORD_W-1:0]  rd_a,
    input logic [WORD_W-1:0]  rd_b,
    input logic [WORD_W-1:0]  br_a,
    input logic [WORD_W-1:0]  br_b,
    input logic               ch_act,
    input ridx_t              ch_idx,
    input word_t              ch_saved
);
    AST_ALIAS_SAME: assert property (@(posedge clk) disable iff (!rst_n)
        (in_src_a[AW-1:0] == in_src_b[AW-1:0]) |-> (rd_a == rd_b) && (br_a == br_b)); // R1

    AST_ZERO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (in_src_a[AW-1:0] == '0) |-> (rd_a == '0) && (br_a == '0)); // R2

    AST_RUN_NOT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ch_act |-> (ch_idx != '0)); // R2

    AST_FRESH_READ: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(in_valid && in_wr_en && !in_is_branch && (in_dst[AW-1:0] != '0))
         && (in_src_a[AW-1:0] == $past(in_dst[AW-1:0])))
        |-> (rd_a == $past(in_wr_data))); // R3

    AST_FLAG_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(in_valid && in_wr_en && in_is_flagrd && !in_is_branch && (in_dst[AW-1:0] != '0))
         && (in_src_b[AW-1:0] == $past(in_dst[AW-1:0])))
        |-> (br_b == $past(in_wr_data))); // R5

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(ch_act) && $stable(ch_idx) && $stable(ch_saved)); // R10
endmodule

bind ireg_branch_file ireg_branch_file_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_src_a     (in_src_a),
    .in_src_b     (in_src_b),
    .in_dst       (in_dst),
    .in_wr_en     (in_wr_en),
    .in_wr_data   (in_wr_data),
    .in_is_branch (in_is_branch),
    .in_is_flagrd (in_is_flagrd),
    .rd_a         (rd_a),
    .rd_b         (rd_b),
    .br_a         (br_a),
    .br_b         (br_b),
    .ch_act       (run.act),
    .ch_idx       (run.idx),
    .ch_saved     (run.saved)
);

// File: tb/test_ireg_branch_file.sv
`timescale 1ns/1ps
module test_ireg_branch_file;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [4:0]  in_src_a = '0;
    logic [4:0]  in_src_b = '0;
    logic [4:0]  in_dst = '0;
    logic        in_wr_en = 1'b0;
    logic [15:0] in_wr_data = '0;
    logic        in_is_branch = 1'b0;
    logic        in_is_flagrd = 1'b0;
    logic        in_stall = 1'b0;
    logic [15:0] rd_a, rd_b, br_a, br_b;

    int errors = 0;
    int checks = 0;

    // behavioural reference state
    int m_reg [16];
    bit m_act;
    int m_idx;
    int m_saved;
    int m_len;

    always #2.5 clk = ~clk;

    ireg_branch_file i_ireg_branch_file (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_src_a(in_src_a), .in_src_b(in_src_b), .in_dst(in_dst),
        .in_wr_en(in_wr_en), .in_wr_data(in_wr_data),
        .in_is_branch(in_is_branch), .in_is_flagrd(in_is_flagrd),
        .in_stall(in_stall),
        .rd_a(rd_a), .rd_b(rd_b), .br_a(br_a), .br_b(br_b)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic issue(input bit v, input int sa, input int sb, input int d,
                         input bit we, input int data, input bit br, input bit fl,
                         input bit st, input string tag);
        int a, b, dd, ea, eb;
        @(negedge clk);
        in_valid = v; in_src_a = 5'(sa); in_src_b = 5'(sb); in_dst = 5'(d);
        in_wr_en = we; in_wr_data = 16'(data); in_is_branch = br;
        in_is_flagrd = fl; in_stall = st;
        #1;
        a = sa & 15; b = sb & 15; dd = d & 15;
        ea = (m_act && m_idx == a) ? m_saved : m_reg[a];
        eb = (m_act && m_idx == b) ? m_saved : m_reg[b];
        chk(tag, "rd_a", int'(rd_a), m_reg[a]);
        chk(tag, "rd_b", int'(rd_b), m_reg[b]);
        chk(tag, "br_a", int'(br_a), ea);
        chk(tag, "br_b", int'(br_b), eb);
        if (v) begin
            bit wr_any, wr_plain;
            wr_any   = we && !br && dd != 0;
            wr_plain = wr_any && !fl;
            if (wr_plain) begin
                if (m_act && m_idx == dd && (a == dd || b == dd) && !st && m_len < 4)
                    m_len++;
                else begin
                    m_act = 1; m_idx = dd; m_saved = m_reg[dd]; m_len = 1;
                end
            end else begin
                m_act = 0;
            end
            if (wr_any) m_reg[dd] = data & 16'hffff;
        end
    endtask

    // convenience wrappers
    task automatic wr(input int sa, input int d, input int data, input string tag);
        issue(1, sa, 0, d, 1, data, 0, 0, 0, tag);
    endtask
    task automatic brn(input int sa, input int sb, input string tag);
        issue(1, sa, sb, 0, 0, 0, 1, 0, 0, tag);
    endtask
    task automatic idle(input int sa, input int sb, input string tag);
        issue(0, sa, sb, 0, 0, 0, 0, 0, 0, tag);
    endtask

    initial begin : watchdog
        #200000;
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) m_reg[i] = 0;
        m_act = 0; m_idx = 0; m_saved = 0; m_len = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R12: reset state
        idle(5, 9, "R12");
        idle(15, 1, "R12");

        // R1: aliased index 18 -> register 2
        wr(0, 18, 16'h1234, "R1");
        idle(2, 18, "R1");
        issue(1, 18, 2, 0, 0, 0, 0, 0, 0, "R1");

        // R2: write to register 0 (and alias 16) ignored
        wr(0, 0, 16'hdead, "R2");
        wr(0, 16, 16'hbeef, "R2");
        brn(0, 16, "R2");

        // R3/R4: single plain write then branch sees old value
        wr(0, 5, 16'h0064, "R4");
        brn(5, 0, "R4");
        issue(1, 5, 5, 0, 0, 0, 0, 0, 0, "R3");

        // R5: flag-read write is visible to branch
        issue(1, 0, 0, 5, 1, 16'h0abc, 0, 1, 0, "R5");
        brn(0, 5, "R5");

        // R6: four-long read-modify-write run
        wr(0, 6, 16'h0010, "R6");
        wr(6, 6, 16'h0020, "R6");
        issue(1, 3, 6, 6, 1, 16'h0030, 0, 0, 0, "R6");
        wr(6, 6, 16'h0040, "R6");
        brn(6, 6, "R6");

        // R7: fifth RMW starts a new run
        wr(0, 7, 16'h0001, "R7");
        wr(7, 7, 16'h0002, "R7");
        wr(7, 7, 16'h0003, "R7");
        wr(7, 7, 16'h0004, "R7");
        wr(7, 7, 16'h0005, "R7");
        brn(7, 1, "R7");

        // R8: stall inside run restarts it
        wr(0, 8, 16'h0100, "R8");
        wr(8, 8, 16'h0200, "R8");
        issue(1, 8, 0, 8, 1, 16'h0300, 0, 0, 1, "R8");
        brn(8, 0, "R8");

        // R9: non-writing instruction breaks run; write without read restarts
        wr(0, 9, 16'h0aaa, "R9");
        issue(1, 9, 0, 0, 0, 0, 0, 0, 0, "R9");
        brn(9, 0, "R9");
        wr(0, 9, 16'h0bbb, "R9");
        wr(0, 9, 16'h0ccc, "R9");
        brn(9, 9, "R9");
        wr(0, 10, 16'h0111, "R9");
        wr(0, 11, 16'h0222, "R9");
        brn(10, 11, "R9");

        // R10: idle gaps inside a run
        wr(0, 12, 16'h7000, "R10");
        idle(12, 0, "R10");
        idle(12, 12, "R10");
        wr(12, 12, 16'h7001, "R10");
        idle(0, 12, "R10");
        brn(12, 0, "R10");

        // R11: only the matching operand substituted
        wr(0, 13, 16'h0d0d, "R11");
        brn(13, 5, "R11");
        wr(0, 14, 16'h0e0e, "R11");
        brn(6, 14, "R11");

        // random mix on a small register pool with aliases
        for (int n = 0; n < 1500; n++) begin
            int r, sa, sb, d;
            bit v, we, br, fl, st;
            r  = int'($urandom_range(0, 99));
            sa = int'($urandom_range(0, 3)) + (($urandom_range(0, 3) == 0) ? 16 : 0);
            sb = int'($urandom_range(0, 3)) + (($urandom_range(0, 3) == 0) ? 16 : 0);
            d  = int'($urandom_range(1, 3)) + (($urandom_range(0, 3) == 0) ? 16 : 0);
            if ($urandom_range(0, 1) == 1) sa = d;
            v  = (r >= 10);
            br = (r >= 10 && r < 30);
            we = !br && ($urandom_range(0, 9) != 0);
            fl = ($urandom_range(0, 9) == 0);
            st = ($urandom_range(0, 7) == 0);
            issue(v, sa, sb, d, we, int'($urandom_range(0, 65535)), br, fl, st,
                  "R6/R7/R8/R9/R10/R11 random");
        end

        idle(0, 0, "R12");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule